// File: doc/BRIEF.md
# Multiphase Rail Fault Shutdown Sequencer

This block sits between a multiphase PWM generator and the power stage of one voltage rail. It passes each phase's PWM and synchronous-rectifier enable through a gate and closes the gates when one of two fault sources trips. The two sources are an external active-high fault line and a level-sensitive current-limit flag. It does not depend on any slow monitoring loop. It reacts directly to its inputs, and it uses a switching-cycle strobe and a one-microsecond tick as its time bases.

An external fault closes every gate of the rail at once. A current-limit trip first turns off the PWM of the primary phase (index 0) at the next switching-cycle boundary. After a fixed delay it shuts the secondary phases in ascending order, one per fixed interval, so the total latency grows linearly with the configured phase count. Outputs stay off and a status bit per source stays set until a clear request arrives while both fault inputs are quiet.

Top module: `fault_shutdown_seq`

## Requirements
- R1: After reset, both status outputs are 0, the active phase count is the maximum (4), and each gated output equals its raw input.
- R2: The 3-bit `phaseCount` is clamped: 0 counts as 1 and values above 4 count as 4. Phases with index at or above the count have their gated PWM and rectifier enable held low.
- R3: The phase count is loaded on every clock edge that the sequencer spends idle. Changes made while a fault is being handled have no effect until one idle edge after the clear.
- R4: `extFault` passes through a two-flop synchronizer. A level that is high at edge e0 forces every gated PWM and rectifier enable low from edge e0+2 on.
- R5: `extFaultLatched` becomes 1 on the same edge that R4 closes the gates.
- R6: After a current-limit trip from idle, the PWM of phase 0 goes low on the first edge at or after the trip edge where `cycleStrobe` is high.
- R7: Counting `usTick` pulses sampled after the trip edge, the 10th pulse turns off the rectifier enable of phase 0 and both outputs of phase 1. It also turns off the PWM of phase 0 if no strobe has done so yet.
- R8: Each further assigned phase k (k ≥ 2) turns off both outputs at tick 10 + 3·(k−1). Once the last assigned phase is off, the sequence ends.
- R9: `clFaultLatched` becomes 1 on any edge where `clTrip` is high.
- R10: A clear is accepted only when `clearReq` is high, the synchronized external fault is low and `clTrip` is low. It reopens all gates and zeroes both status bits at that edge. Otherwise closed gates stay closed.
- R11: When the synchronized external fault and a current-limit trip arrive on the same edge, or when the external fault arrives during a current-limit sequence, every gate closes at once and both status bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extFault | input | 1 | Asynchronous external fault, active high |
| clTrip | input | 1 | Current-limit comparator flag, level |
| cycleStrobe | input | 1 | One-clock pulse per switching cycle |
| usTick | input | 1 | One-clock pulse per microsecond |
| phaseCount | input | 3 | Requested number of rail phases |
| clearReq | input | 1 | Request to leave the fault state |
| pwmIn | input | 4 | Raw PWM per phase |
| srEnIn | input | 4 | Raw rectifier enable per phase |
| pwmOut | output | 4 | Gated PWM per phase |
| srEnOut | output | 4 | Gated rectifier enable per phase |
| extFaultLatched | output | 1 | Sticky external fault status |
| clFaultLatched | output | 1 | Sticky current-limit status |

## Verification
The external-fault shutdown and the start of a current-limit sequence can land on the same edge. The bench provokes this by raising the external line two clocks before it raises the current-limit flag, so the synchronized level and the flag are sampled together. It then expects every gate to close on that edge and both status bits to be set. A second case injects the external fault partway through the tick-driven sequence. In both cases a behavioural model that advances on each clock predicts every gated bit, and the bench compares it against the outputs.

// File: rtl/fault_seq_pkg.sv
package fault_seq_pkg;
  parameter int unsigned FS_MAX_PHASES = 4;
  localparam int unsigned FS_CNT_W = $clog2(FS_MAX_PHASES + 1);

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_CL_RUN  = 2'd1,
    SEQ_ALL_OFF = 2'd2
  } seqState_t;

  typedef struct packed {
    logic                     restore;
    logic                     loadCount;
    logic [FS_MAX_PHASES-1:0] pwmKill;
    logic [FS_MAX_PHASES-1:0] srKill;
  } gateStrobe_t;
endpackage

// File: rtl/fault_seq_ctrl.sv
module fault_seq_ctrl
  import fault_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned CL_BASE_TICKS = 10,
  parameter int unsigned CL_STEP_TICKS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                extFaultAsync,
  input  logic                clFlag,
  input  logic                cycleStrobe,
  input  logic                usTick,
  input  logic                clearReq,
  input  logic [FS_CNT_W-1:0] activeCount,
  output gateStrobe_t         strb,
  output logic                extSticky,
  output logic                clSticky
);
  localparam int unsigned P      = FS_MAX_PHASES;
  localparam int unsigned TICK_W = $clog2(CL_BASE_TICKS + CL_STEP_TICKS * P + 2);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   extSync;
  seqState_t              state, stateNext;
  logic                   primaryPend, pendNext;
  logic [TICK_W-1:0]      tickCnt, tickLoad, tickNext, lastDl;
  logic [P-1:0]           stepKill, pwmKillV, srKillV;
  logic                   restoreNow, seqDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], extFaultAsync};
  end
  assign extSync = syncChain[SYNC_STAGES-1];

  assign tickNext   = tickCnt + TICK_W'(usTick);
  assign restoreNow = (state != SEQ_IDLE) && clearReq && !extSync && !clFlag;

  always_comb begin
    if (activeCount <= FS_CNT_W'(1)) lastDl = TICK_W'(CL_BASE_TICKS);
    else lastDl = TICK_W'(CL_BASE_TICKS + CL_STEP_TICKS * (int'(activeCount) - 2));
  end
  assign seqDone = tickNext >= lastDl;

  always_comb begin
    stepKill = '0;
    for (int k = 0; k < int'(P); k++) begin
      if (FS_CNT_W'(k) < activeCount &&
          tickNext >= TICK_W'((k == 0) ? CL_BASE_TICKS : CL_BASE_TICKS + CL_STEP_TICKS * (k - 1)))
        stepKill[k] = 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    pendNext  = primaryPend;
    tickLoad  = tickCnt;
    pwmKillV  = '0;
    srKillV   = '0;
    if (restoreNow) begin
      stateNext = SEQ_IDLE;
      pendNext  = 1'b0;
      tickLoad  = '0;
    end else if (extSync) begin
      pwmKillV  = '1;
      srKillV   = '1;
      stateNext = SEQ_ALL_OFF;
      pendNext  = 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (clFlag) begin
            stateNext   = SEQ_CL_RUN;
            tickLoad    = '0;
            pwmKillV[0] = cycleStrobe;
            pendNext    = !cycleStrobe;
          end
        end
        SEQ_CL_RUN: begin
          tickLoad = tickNext;
          if (primaryPend && cycleStrobe) begin
            pwmKillV[0] = 1'b1;
            pendNext    = 1'b0;
          end
          pwmKillV = pwmKillV | stepKill;
          srKillV  = stepKill;
          if (stepKill[0]) pendNext = 1'b0;
          if (seqDone) stateNext = SEQ_ALL_OFF;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.restore   = restoreNow;
    strb.loadCount = (state == SEQ_IDLE);
    strb.pwmKill   = pwmKillV;
    strb.srKill    = srKillV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= SEQ_IDLE;
      primaryPend <= 1'b0;
      tickCnt     <= '0;
      extSticky   <= 1'b0;
      clSticky    <= 1'b0;
    end else begin
      state       <= stateNext;
      primaryPend <= pendNext;
      tickCnt     <= tickLoad;
      if (restoreNow) begin
        extSticky <= 1'b0;
        clSticky  <= 1'b0;
      end else begin
        if (extSync) extSticky <= 1'b1;
        if (clFlag)  clSticky  <= 1'b1;
      end
    end
  end

  p_ext_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    extSync |=> extSticky);

  p_cl_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    clFlag |=> clSticky);

  p_clear_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clSticky) |-> ($past(clearReq) && !$past(clFlag)));

  p_primary_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_CL_RUN && cycleStrobe) |=> !primaryPend);
endmodule

// File: rtl/fault_seq_gate.sv
module fault_seq_gate
  import fault_seq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  gateStrobe_t              strb,
  input  logic [FS_CNT_W-1:0]      phaseCount,
  input  logic [FS_MAX_PHASES-1:0] pwmIn,
  input  logic [FS_MAX_PHASES-1:0] srEnIn,
  output logic [FS_MAX_PHASES-1:0] pwmOut,
  output logic [FS_MAX_PHASES-1:0] srEnOut,
  output logic [FS_CNT_W-1:0]      activeCount
);
  localparam int unsigned P = FS_MAX_PHASES;

  logic [FS_CNT_W-1:0] clampedCount;
  logic [P-1:0]        pwmMask, srMask, assigned;

  always_comb begin
    if (phaseCount == '0)                   clampedCount = FS_CNT_W'(1);
    else if (phaseCount > FS_CNT_W'(P))     clampedCount = FS_CNT_W'(P);
    else                                    clampedCount = phaseCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               activeCount <= FS_CNT_W'(P);
    else if (strb.loadCount) activeCount <= clampedCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmMask <= '1;
      srMask  <= '1;
    end else if (strb.restore) begin
      pwmMask <= '1;
      srMask  <= '1;
    end else begin
      pwmMask <= pwmMask & ~strb.pwmKill;
      srMask  <= srMask & ~strb.srKill;
    end
  end

  for (genvar i = 0; i < int'(P); i++) begin : g_lane
    assign assigned[i] = FS_CNT_W'(i) < activeCount;
    assign pwmOut[i]   = pwmIn[i] & pwmMask[i] & assigned[i];
    assign srEnOut[i]  = srEnIn[i] & srMask[i] & assigned[i];

    p_sr_with_pwm_r7: assert property (@(posedge clk) disable iff (!rstN)
      !srMask[i] |-> !pwmMask[i]);

    if (i > 0) begin : g_order
      p_order_r8: assert property (@(posedge clk) disable iff (!rstN)
        !pwmMask[i] |-> !pwmMask[i-1]);
    end
  end

  p_count_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    activeCount >= FS_CNT_W'(1) && activeCount <= FS_CNT_W'(P));

  p_count_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCount |=> $stable(activeCount));
endmodule

// File: rtl/fault_shutdown_seq.sv
module fault_shutdown_seq
  import fault_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned CL_BASE_TICKS = 10,
  parameter int unsigned CL_STEP_TICKS = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     extFault,
  input  logic                     clTrip,
  input  logic                     cycleStrobe,
  input  logic                     usTick,
  input  logic [FS_CNT_W-1:0]      phaseCount,
  input  logic                     clearReq,
  input  logic [FS_MAX_PHASES-1:0] pwmIn,
  input  logic [FS_MAX_PHASES-1:0] srEnIn,
  output logic [FS_MAX_PHASES-1:0] pwmOut,
  output logic [FS_MAX_PHASES-1:0] srEnOut,
  output logic                     extFaultLatched,
  output logic                     clFaultLatched
);
  gateStrobe_t         strb;
  logic [FS_CNT_W-1:0] activeCount;

  fault_seq_ctrl #(
    .SYNC_STAGES  (SYNC_STAGES),
    .CL_BASE_TICKS(CL_BASE_TICKS),
    .CL_STEP_TICKS(CL_STEP_TICKS)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .extFaultAsync(extFault),
    .clFlag       (clTrip),
    .cycleStrobe  (cycleStrobe),
    .usTick       (usTick),
    .clearReq     (clearReq),
    .activeCount  (activeCount),
    .strb         (strb),
    .extSticky    (extFaultLatched),
    .clSticky     (clFaultLatched)
  );

  fault_seq_gate u_gate (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .phaseCount (phaseCount),
    .pwmIn      (pwmIn),
    .srEnIn     (srEnIn),
    .pwmOut     (pwmOut),
    .srEnOut    (srEnOut),
    .activeCount(activeCount)
  );
endmodule

// File: tb/tb_fault_shutdown_seq.sv
module tb_fault_shutdown_seq;
  import fault_seq_pkg::*;
  localparam int P    = FS_MAX_PHASES;
  localparam int BASE = 10;
  localparam int STEP = 3;

  logic clk = 1'b0;
  logic rstN, extFault, clTrip, cycleStrobe, usTick, clearReq;
  logic [FS_CNT_W-1:0] phaseCount;
  logic [P-1:0] pwmIn, srEnIn, pwmOut, srEnOut;
  logic extFaultLatched, clFaultLatched;

  fault_shutdown_seq dut (
    .clk(clk), .rstN(rstN), .extFault(extFault), .clTrip(clTrip),
    .cycleStrobe(cycleStrobe), .usTick(usTick), .phaseCount(phaseCount),
    .clearReq(clearReq), .pwmIn(pwmIn), .srEnIn(srEnIn), .pwmOut(pwmOut),
    .srEnOut(srEnOut), .extFaultLatched(extFaultLatched),
    .clFaultLatched(clFaultLatched)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  int mState, mCnt, mTick;
  bit mS1, mS2, mPend, mExtSt, mClSt;
  bit [P-1:0] mPwm, mSr;

  function automatic int clampCnt(int v);
    if (v == 0) return 1;
    if (v > P) return P;
    return v;
  endfunction

  task automatic modelStep();
    int nState;
    int t;
    int last;
    int dl;
    bit restore;
    if (!rstN) begin
      mState = 0; mCnt = P; mTick = 0; mS1 = 0; mS2 = 0; mPend = 0;
      mExtSt = 0; mClSt = 0; mPwm = '1; mSr = '1;
      return;
    end
    nState = mState;
    restore = (mState != 0) && clearReq && !mS2 && !clTrip;
    if (restore) begin
      mPwm = '1; mSr = '1; nState = 0; mExtSt = 0; mClSt = 0; mPend = 0; mTick = 0;
    end else begin
      if (mS2) mExtSt = 1;
      if (clTrip) mClSt = 1;
      if (mS2) begin
        mPwm = '0; mSr = '0; nState = 2; mPend = 0;
      end else if (mState == 0 && clTrip) begin
        nState = 1; mTick = 0;
        if (cycleStrobe) mPwm[0] = 0;
        mPend = !cycleStrobe;
      end else if (mState == 1) begin
        t = mTick + int'(usTick);
        mTick = t;
        if (mPend && cycleStrobe) begin mPwm[0] = 0; mPend = 0; end
        for (int k = 0; k < mCnt; k++) begin
          dl = (k == 0) ? BASE : BASE + STEP * (k - 1);
          if (t >= dl) begin
            mPwm[k] = 0; mSr[k] = 0;
            if (k == 0) mPend = 0;
          end
        end
        last = (mCnt == 1) ? BASE : BASE + STEP * (mCnt - 2);
        if (t >= last) nState = 2;
      end
    end
    if (mState == 0) mCnt = clampCnt(int'(phaseCount));
    mState = nState;
    mS2 = mS1;
    mS1 = extFault;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit [P-1:0] ePwm, eSr;
    for (int i = 0; i < P; i++) begin
      ePwm[i] = pwmIn[i] & mPwm[i] & (i < mCnt);
      eSr[i]  = srEnIn[i] & mSr[i] & (i < mCnt);
    end
    check(curReq, "model pwmOut", 32'(pwmOut), 32'(ePwm));
    check(curReq, "model srEnOut", 32'(srEnOut), 32'(eSr));
    check(curReq, "model extFaultLatched", 32'(extFaultLatched), 32'(mExtSt));
    check(curReq, "model clFaultLatched", 32'(clFaultLatched), 32'(mClSt));
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic tickPulse();
    usTick = 1'b1;
    cyc();
    usTick = 1'b0;
    cyc();
    cyc();
  endtask

  task automatic doClear();
    extFault = 1'b0;
    clTrip = 1'b0;
    repeat (3) cyc();
    clearReq = 1'b1;
    cyc();
    clearReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; extFault = 1'b0; clTrip = 1'b0; cycleStrobe = 1'b0;
    usTick = 1'b0; clearReq = 1'b0; phaseCount = 3'd4;
    pwmIn = '1; srEnIn = '1;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1: reset state and transparent gating
    curReq = "R1";
    check("R1", "ext status after reset", 32'(extFaultLatched), 0);
    check("R1", "cl status after reset", 32'(clFaultLatched), 0);
    check("R1", "pwm pass-through", 32'(pwmOut), 32'hF);
    for (int n = 0; n < 8; n++) begin
      pwmIn = 4'(n * 5 + 3);
      srEnIn = ~4'(n * 3);
      cyc();
    end
    pwmIn = '1; srEnIn = '1;
    cyc();

    // R2: phase count clamp and unassigned phases
    curReq = "R2";
    phaseCount = 3'd2; cyc();
    check("R2", "count 2 pwm", 32'(pwmOut), 32'h3);
    phaseCount = 3'd0; cyc();
    check("R2", "count 0 clamps to 1", 32'(srEnOut), 32'h1);
    phaseCount = 3'd7; cyc();
    check("R2", "count 7 clamps to 4", 32'(pwmOut), 32'hF);
    phaseCount = 3'd4; cyc();

    // R4/R5: external fault through synchronizer
    curReq = "R4";
    extFault = 1'b1;
    cyc(); cyc();
    check("R4", "gates still open before sync", 32'(pwmOut), 32'hF);
    cyc();
    check("R4", "all pwm off", 32'(pwmOut), 0);
    check("R4", "all sr off", 32'(srEnOut), 0);
    check("R5", "ext status set", 32'(extFaultLatched), 1);

    // R10: clear ignored while fault active
    curReq = "R10";
    clearReq = 1'b1; cyc(); clearReq = 1'b0;
    check("R10", "clear ignored under ext fault", 32'(pwmOut), 0);
    check("R10", "ext status kept", 32'(extFaultLatched), 1);
    doClear();
    check("R10", "gates reopened", 32'(pwmOut), 32'hF);
    check("R10", "ext status cleared", 32'(extFaultLatched), 0);

    // R6/R7/R8/R9: current-limit sequence with 4 phases
    curReq = "R6";
    clTrip = 1'b1; cyc();
    check("R9", "cl status set", 32'(clFaultLatched), 1);
    check("R6", "primary waits for strobe", 32'(pwmOut), 32'hF);
    cyc(); cyc();
    cycleStrobe = 1'b1; cyc(); cycleStrobe = 1'b0;
    check("R6", "primary pwm off at strobe", 32'(pwmOut), 32'hE);
    check("R6", "sr untouched at strobe", 32'(srEnOut), 32'hF);
    curReq = "R7";
    repeat (9) tickPulse();
    check("R7", "before tick 10 pwm", 32'(pwmOut), 32'hE);
    check("R7", "before tick 10 sr", 32'(srEnOut), 32'hF);
    tickPulse();
    check("R7", "tick 10 pwm", 32'(pwmOut), 32'hC);
    check("R7", "tick 10 sr", 32'(srEnOut), 32'hC);
    curReq = "R8";
    tickPulse(); tickPulse();
    check("R8", "tick 12 pwm", 32'(pwmOut), 32'hC);
    tickPulse();
    check("R8", "tick 13 pwm", 32'(pwmOut), 32'h8);
    check("R8", "tick 13 sr", 32'(srEnOut), 32'h8);
    tickPulse(); tickPulse();
    check("R8", "tick 15 pwm", 32'(pwmOut), 32'h8);
    tickPulse();
    check("R8", "tick 16 pwm", 32'(pwmOut), 32'h0);
    check("R8", "tick 16 sr", 32'(srEnOut), 32'h0);
    curReq = "R10";
    clearReq = 1'b1; cyc();
    check("R10", "clear ignored with clTrip high", 32'(pwmOut), 0);
    clTrip = 1'b0; cyc(); clearReq = 1'b0;
    check("R10", "restored after quiet clear", 32'(pwmOut), 32'hF);
    check("R10", "cl status cleared", 32'(clFaultLatched), 0);

    // R3 with R7 backstop: count frozen during sequence
    curReq = "R3";
    phaseCount = 3'd1; cyc();
    check("R3", "count 1 loaded when idle", 32'(pwmOut), 32'h1);
    clTrip = 1'b1; cyc(); clTrip = 1'b0;
    phaseCount = 3'd4;
    repeat (9) tickPulse();
    check("R3", "new count ignored during fault", 32'(pwmOut), 32'h1);
    tickPulse();
    check("R7", "backstop kills primary pwm", 32'(pwmOut), 0);
    check("R7", "backstop kills primary sr", 32'(srEnOut), 0);
    clearReq = 1'b1; cyc(); clearReq = 1'b0;
    check("R3", "count not reloaded on clear edge", 32'(pwmOut), 32'h1);
    cyc();
    check("R3", "count reloaded once idle", 32'(pwmOut), 32'hF);

    // R11: simultaneous sources, and ext during sequence
    curReq = "R11";
    extFault = 1'b1; cyc(); cyc();
    clTrip = 1'b1; cyc(); clTrip = 1'b0;
    check("R11", "same edge pwm", 32'(pwmOut), 0);
    check("R11", "same edge sr", 32'(srEnOut), 0);
    check("R11", "same edge ext status", 32'(extFaultLatched), 1);
    check("R11", "same edge cl status", 32'(clFaultLatched), 1);
    doClear();
    check("R11", "restored", 32'(pwmOut), 32'hF);
    clTrip = 1'b1; cycleStrobe = 1'b1; cyc(); clTrip = 1'b0; cycleStrobe = 1'b0;
    check("R6", "strobe on trip edge", 32'(pwmOut), 32'hE);
    repeat (3) tickPulse();
    extFault = 1'b1; cyc(); cyc(); cyc();
    check("R11", "ext mid-sequence pwm", 32'(pwmOut), 0);
    check("R11", "ext mid-sequence sr", 32'(srEnOut), 0);
    check("R11", "ext mid-sequence status", 32'(extFaultLatched), 1);
    doClear();
    check("R10", "final restore", 32'(srEnOut), 32'hF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule